// File: doc/BRIEF.md
# DRAM Dynamic Termination Selector

This block sits on the DRAM side of a memory interface and decides, every clock cycle, which on-die termination code the data pins and the strobe pins should present. It watches mode-register writes and keeps two termination settings from them: a nominal code used while the bus is idle and a write code used only while write data is arriving. Write commands open a write window of fixed length. During that window the block swaps to the write code with no intermediate nominal cycle, and when the window closes it swaps back.

Two mode flags taken from the same mode register limit the swap. DLL-off operation forbids the write code. Write-leveling operation forbids it as well, turns the data pins off and keeps the nominal code on the strobe pins only. Changes to the nominal register do not act at once. They wait a latency chosen by whether termination is being turned on or off, and an uncertainty flag is raised for that whole period. The termination input can be tied high with the nominal code set to off. The pins are then terminated only during writes.

Top module: `odt_dyn_term`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dq_term` and `dqs_term` are 3'b000 and `term_unsure` is 0. All mode fields reset to zero.
- R2: A mode write with `mr_ba`=2'b01 loads the nominal code {mr_addr[9], mr_addr[6], mr_addr[2]}, write leveling from mr_addr[7] and DLL-off from mr_addr[0]. A write with `mr_ba`=2'b10 loads the 2-bit write field from mr_addr[10:9], which maps 01→3'b001, 10→3'b010, 11→3'b100 and 00→dynamic switching disabled. The write field takes effect in the cycle after the write. Writes to banks 2'b00 and 2'b11 change nothing.
- R3: With `odt` low, both outputs are 3'b000.
- R4: With a nonzero write field, `odt` high and neither mode flag set, the write command sampled at a clock edge makes `dq_term` show the mapped write code from that edge for WIN = CWL + BURST_LEN/2 + 1 cycles. After that the nominal code returns. With the write field at 00, the nominal code stays throughout.
- R5: A write command that arrives while a window is open restarts the full window, so the write code is held with no nominal cycle between the two bursts.
- R6: A write-field change made in the middle of a burst appears on the outputs in the next cycle, while the burst continues.
- R7: With DLL-off set, write commands never select the write code, and the nominal code applies.
- R8: With the nominal code 3'b000, `odt` high and a nonzero write field, the outputs are 3'b000 when idle and carry the write code only inside write windows.
- R9: With write leveling set, `dq_term` is 3'b000, `dqs_term` carries the nominal code when `odt` is high, and write commands do not select the write code.
- R10: A nominal-register write commits its three fields together after D_ON = ODTL_ON + T_AON + T_MOD + 1 cycles if the new nominal code is nonzero, and after D_OFF = ODTL_OFF + T_AOF + T_MOD + 1 cycles otherwise. `term_unsure` is high for exactly those cycles and the outputs keep the previous settings during them. A further nominal-register write restarts the wait and discards the earlier pending value.
- R11: Outside write leveling, `dqs_term` equals `dq_term`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_wr | input | 1 | Mode-register write strobe |
| mr_ba | input | 2 | Mode-register select (01 nominal register, 10 write register) |
| mr_addr | input | ADDR_W | Mode-register write data |
| odt | input | 1 | Termination enable input |
| wr_cmd | input | 1 | Write command strobe |
| dq_term | output | 3 | Termination code for the data pins |
| dqs_term | output | 3 | Termination code for the strobe pins |
| term_unsure | output | 1 | High while a nominal-register change is pending |

## Verification
The main swap is exercised with an isolated write, which checks the window length on both edges, and with a second command five cycles into a window, which separates a reloading counter from one that lets the first burst lapse. A write-register change in mid-burst and a write with the write field at zero test whether the code is read live or latched. DLL-off, write leveling and a nominal code of zero are each paired with write commands to show which of the two codes wins. Nominal-register writes are timed cycle by cycle with on and off latencies, including a restarted wait that must never expose the superseded value.

// File: rtl/odt_dyn_pkg.sv
`timescale 1ns/1ps
package odt_dyn_pkg;
   localparam int TERM_W = 3;
   typedef logic [TERM_W-1:0] term_t;

   typedef enum logic [1:0] {
      BANK_MR0 = 2'b00,
      BANK_NOM = 2'b01,
      BANK_WRT = 2'b10,
      BANK_MR3 = 2'b11
   } mr_bank_e;

   // write field into the shared 3-bit code space; 00 stays off
   function automatic term_t map_wr(input logic [1:0] f);
      return {f == 2'b11, f == 2'b10, f == 2'b01};
   endfunction
endpackage

// File: rtl/odt_mr_regs.sv
`timescale 1ns/1ps
module odt_mr_regs
   import odt_dyn_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int D_ON   = 18,
   parameter int D_OFF  = 19
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mr_wr,
   input  logic [1:0]        mr_ba,
   input  logic [ADDR_W-1:0] mr_addr,
   output term_t             nom_code,
   output logic [1:0]        wr_field,
   output logic              wl_on,
   output logic              dll_off,
   output logic              unsure
);
   localparam int DMAX  = (D_ON > D_OFF) ? D_ON : D_OFF;
   localparam int CNT_W = $clog2(DMAX + 1);

   logic [CNT_W-1:0] pcnt;
   term_t            pend_nom;
   logic             pend_wl;
   logic             pend_dll;
   term_t            new_nom;
   logic             wr_nom_bank;
   logic             wr_wrt_bank;
   logic             unused_bits;

   assign new_nom     = {mr_addr[9], mr_addr[6], mr_addr[2]};
   assign wr_nom_bank = mr_wr && (mr_ba == BANK_NOM);
   assign wr_wrt_bank = mr_wr && (mr_ba == BANK_WRT);
   assign unused_bits = ^{mr_addr[ADDR_W-1:11], mr_addr[8], mr_addr[5:3], mr_addr[1]};

   always_ff @(posedge clk) begin
      if (rst) begin
         pcnt     <= '0;
         pend_nom <= '0;
         pend_wl  <= 1'b0;
         pend_dll <= 1'b0;
         nom_code <= '0;
         wl_on    <= 1'b0;
         dll_off  <= 1'b0;
         wr_field <= 2'b00;
      end else begin
         if (wr_wrt_bank)
            wr_field <= mr_addr[10:9];
         if (wr_nom_bank) begin
            pend_nom <= new_nom;
            pend_wl  <= mr_addr[7];
            pend_dll <= mr_addr[0];
            pcnt     <= (new_nom != '0) ? CNT_W'(D_ON) : CNT_W'(D_OFF);
         end else if (pcnt != '0) begin
            pcnt <= pcnt - 1'b1;
            if (pcnt == CNT_W'(1)) begin
               nom_code <= pend_nom;
               wl_on    <= pend_wl;
               dll_off  <= pend_dll;
            end
         end
      end
   end

   assign unsure = (pcnt != '0);
endmodule

// File: rtl/odt_wr_track.sv
`timescale 1ns/1ps
module odt_wr_track #(
   parameter int WIN = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic wr_cmd,
   output logic wr_act
);
   localparam int CW = $clog2(WIN + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (wr_cmd)
         cnt <= CW'(WIN);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign wr_act = (cnt != '0);
endmodule

// File: rtl/odt_term_mux.sv
`timescale 1ns/1ps
module odt_term_mux
   import odt_dyn_pkg::*;
(
   input  logic       odt,
   input  logic       wr_act,
   input  term_t      nom_code,
   input  logic [1:0] wr_field,
   input  logic       wl_on,
   input  logic       dll_off,
   output term_t      dq_n,
   output term_t      dqs_n
);
   logic [1:0] wr_eff;

   assign wr_eff = (dll_off || wl_on) ? 2'b00 : wr_field;

   always_comb begin
      if (!odt) begin
         dq_n  = '0;
         dqs_n = '0;
      end else if (wl_on) begin
         dq_n  = '0;
         dqs_n = nom_code;
      end else if (wr_act && (wr_eff != 2'b00)) begin
         dq_n  = map_wr(wr_eff);
         dqs_n = map_wr(wr_eff);
      end else begin
         dq_n  = nom_code;
         dqs_n = nom_code;
      end
   end
endmodule

// File: rtl/odt_dyn_term.sv
`timescale 1ns/1ps
module odt_dyn_term
   import odt_dyn_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int CWL       = 5,
   parameter int BURST_LEN = 8,
   parameter int ODTL_ON   = 4,
   parameter int ODTL_OFF  = 4,
   parameter int T_AON     = 1,
   parameter int T_AOF     = 2,
   parameter int T_MOD     = 12,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mr_wr,
   input  logic [1:0]        mr_ba,
   input  logic [ADDR_W-1:0] mr_addr,
   input  logic              odt,
   input  logic              wr_cmd,
   output logic [2:0]        dq_term,
   output logic [2:0]        dqs_term,
   output logic              term_unsure
);
   localparam int WIN   = CWL + BURST_LEN / 2 + 1;
   localparam int D_ON  = ODTL_ON + T_AON + T_MOD + 1;
   localparam int D_OFF = ODTL_OFF + T_AOF + T_MOD + 1;

   generate
      if (!(BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
         $error("odt_dyn_term: BURST_LEN must be 4 or 8");
      end
      if (ADDR_W < 12) begin : g_bad_aw
         $error("odt_dyn_term: ADDR_W must be at least 12");
      end
      if (CWL < 1) begin : g_bad_cwl
         $error("odt_dyn_term: CWL must be positive");
      end
   endgenerate

   term_t      nom_code;
   logic [1:0] wr_field;
   logic       wl_on;
   logic       dll_off;
   logic       wr_act;
   term_t      dq_n;
   term_t      dqs_n;

   odt_mr_regs #(
      .ADDR_W (ADDR_W),
      .D_ON   (D_ON),
      .D_OFF  (D_OFF)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .mr_wr    (mr_wr),
      .mr_ba    (mr_ba),
      .mr_addr  (mr_addr),
      .nom_code (nom_code),
      .wr_field (wr_field),
      .wl_on    (wl_on),
      .dll_off  (dll_off),
      .unsure   (term_unsure)
   );

   odt_wr_track #(
      .WIN (WIN)
   ) u_track (
      .clk    (clk),
      .rst    (rst),
      .wr_cmd (wr_cmd),
      .wr_act (wr_act)
   );

   odt_term_mux u_mux (
      .odt      (odt),
      .wr_act   (wr_act),
      .nom_code (nom_code),
      .wr_field (wr_field),
      .wl_on    (wl_on),
      .dll_off  (dll_off),
      .dq_n     (dq_n),
      .dqs_n    (dqs_n)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk) begin
            if (rst) begin
               dq_term  <= '0;
               dqs_term <= '0;
            end else begin
               dq_term  <= dq_n;
               dqs_term <= dqs_n;
            end
         end
      end else begin : g_comb_out
         assign dq_term  = dq_n;
         assign dqs_term = dqs_n;
      end
   endgenerate
endmodule

// File: rtl/odt_dyn_term_chk.sv
`timescale 1ns/1ps
module odt_dyn_term_chk #(
   parameter bit REG_OUT = 1'b0
) (
   input logic       clk,
   input logic       rst,
   input logic       mr_wr,
   input logic [1:0] mr_ba,
   input logic       odt,
   input logic       wr_cmd,
   input logic [2:0] dq_term,
   input logic [2:0] dqs_term,
   input logic       term_unsure,
   input logic [1:0] wr_field,
   input logic       wl_on,
   input logic       dll_off
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (dq_term == 3'b000 && dqs_term == 3'b000 && !term_unsure));

   // R10
   nom_wait_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (mr_wr && mr_ba == 2'b01) |=> term_unsure);

   generate
      if (!REG_OUT) begin : g_comb_props
         // R3
         odt_low_off_chk: assert property (@(posedge clk) disable iff (rst)
            !odt |-> (dq_term == 3'b000 && dqs_term == 3'b000));

         // R4
         write_swap_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_cmd && odt && wr_field != 2'b00 && !dll_off && !wl_on && !mr_wr && !term_unsure)
            |=> (!odt || dq_term != 3'b000));

         // R9
         wl_dq_off_chk: assert property (@(posedge clk) disable iff (rst)
            wl_on |-> (dq_term == 3'b000));

         // R11
         strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
            !wl_on |-> (dqs_term == dq_term));
      end
   endgenerate
endmodule

bind odt_dyn_term odt_dyn_term_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .mr_wr       (mr_wr),
   .mr_ba       (mr_ba),
   .odt         (odt),
   .wr_cmd      (wr_cmd),
   .dq_term     (dq_term),
   .dqs_term    (dqs_term),
   .term_unsure (term_unsure),
   .wr_field    (wr_field),
   .wl_on       (wl_on),
   .dll_off     (dll_off)
);

// File: tb/odt_dyn_term_test.sv
`timescale 1ns/1ps
module odt_dyn_term_test;
   localparam int AW    = 14;
   localparam int WIN   = 5 + 8 / 2 + 1;
   localparam int D_ON  = 4 + 1 + 12 + 1;
   localparam int D_OFF = 4 + 2 + 12 + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mr_wr = 1'b0;
   logic [1:0]    mr_ba = 2'b00;
   logic [AW-1:0] mr_addr = '0;
   logic          odt = 1'b0;
   logic          wr_cmd = 1'b0;
   logic [2:0]    dq_term;
   logic [2:0]    dqs_term;
   logic          term_unsure;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   odt_dyn_term uut (
      .clk         (clk),
      .rst         (rst),
      .mr_wr       (mr_wr),
      .mr_ba       (mr_ba),
      .mr_addr     (mr_addr),
      .odt         (odt),
      .wr_cmd      (wr_cmd),
      .dq_term     (dq_term),
      .dqs_term    (dqs_term),
      .term_unsure (term_unsure)
   );

   function automatic logic [AW-1:0] nom_word(input logic [2:0] c, input logic wl, input logic dll);
      logic [AW-1:0] w = '0;
      w[9] = c[2];
      w[6] = c[1];
      w[2] = c[0];
      w[7] = wl;
      w[0] = dll;
      return w;
   endfunction

   function automatic logic [AW-1:0] wrt_word(input logic [1:0] f);
      logic [AW-1:0] w = '0;
      w[10:9] = f;
      return w;
   endfunction

   task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic chk_pair(input string req, input logic [2:0] e_dq, input logic [2:0] e_dqs, input logic e_un);
      chk({req, " dq"}, dq_term, e_dq);
      chk({req, " dqs"}, dqs_term, e_dqs);
      chk({req, " unsure"}, {2'b00, term_unsure}, {2'b00, e_un});
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic mrw(input logic [1:0] ba, input logic [AW-1:0] a);
      @(negedge clk);
      mr_wr   = 1'b1;
      mr_ba   = ba;
      mr_addr = a;
      @(negedge clk);
      mr_wr   = 1'b0;
      mr_addr = '0;
   endtask

   task automatic wcmd();
      @(negedge clk);
      wr_cmd = 1'b1;
      @(negedge clk);
      wr_cmd = 1'b0;
   endtask

   task automatic t_reset();
      tick(2);
      chk_pair("R1 in reset", 3'b000, 3'b000, 1'b0);
      rst = 1'b0;
      odt = 1'b1;
      tick(1);
      chk_pair("R1 after reset", 3'b000, 3'b000, 1'b0);
   endtask

   task automatic t_nominal_wait();
      mrw(2'b01, nom_word(3'b011, 1'b0, 1'b0));
      chk_pair("R10 window opens", 3'b000, 3'b000, 1'b1);
      tick(D_ON - 1);
      chk_pair("R10 last uncertain cycle", 3'b000, 3'b000, 1'b1);
      tick(1);
      chk_pair("R2 nominal committed", 3'b011, 3'b011, 1'b0);
      // restart: 101 must never appear
      mrw(2'b01, nom_word(3'b101, 1'b0, 1'b0));
      tick(5);
      mrw(2'b01, nom_word(3'b110, 1'b0, 1'b0));
      tick(D_ON - 1);
      chk_pair("R10 restart keeps old", 3'b011, 3'b011, 1'b1);
      tick(1);
      chk_pair("R10 restart commits last", 3'b110, 3'b110, 1'b0);
   endtask

   task automatic t_ignored_banks();
      mrw(2'b00, '1);
      chk_pair("R2 bank 00 ignored", 3'b110, 3'b110, 1'b0);
      mrw(2'b11, '1);
      chk_pair("R2 bank 11 ignored", 3'b110, 3'b110, 1'b0);
      wcmd();
      chk_pair("R4 write field 00 keeps nominal", 3'b110, 3'b110, 1'b0);
      tick(WIN);
   endtask

   task automatic t_odt_low();
      @(negedge clk);
      odt = 1'b0;
      tick(1);
      chk_pair("R3 odt low", 3'b000, 3'b000, 1'b0);
      odt = 1'b1;
      tick(1);
      chk_pair("R3 odt high again", 3'b110, 3'b110, 1'b0);
   endtask

   task automatic t_single_write();
      mrw(2'b10, wrt_word(2'b01));
      chk_pair("R4 idle nominal", 3'b110, 3'b110, 1'b0);
      wcmd();
      chk_pair("R4 window first cycle", 3'b001, 3'b001, 1'b0);
      tick(WIN - 1);
      chk_pair("R4 window last cycle", 3'b001, 3'b001, 1'b0);
      tick(1);
      chk_pair("R4 back to nominal", 3'b110, 3'b110, 1'b0);
   endtask

   task automatic t_back_to_back();
      wcmd();
      for (int i = 1; i <= 3; i++) begin
         tick(1);
         chk_pair("R5 first burst", 3'b001, 3'b001, 1'b0);
      end
      wcmd();
      chk_pair("R5 second command", 3'b001, 3'b001, 1'b0);
      for (int i = 1; i < WIN; i++) begin
         tick(1);
         chk_pair("R5 no nominal gap", 3'b001, 3'b001, 1'b0);
      end
      tick(1);
      chk_pair("R5 end of merged bursts", 3'b110, 3'b110, 1'b0);
   endtask

   task automatic t_mid_burst_mr();
      wcmd();
      chk_pair("R6 burst starts", 3'b001, 3'b001, 1'b0);
      mrw(2'b10, wrt_word(2'b10));
      chk_pair("R6 new write code mid-burst", 3'b010, 3'b010, 1'b0);
      tick(WIN - 3);
      chk_pair("R6 burst still open", 3'b010, 3'b010, 1'b0);
      tick(1);
      chk_pair("R6 burst closed", 3'b110, 3'b110, 1'b0);
   endtask

   task automatic t_dll_off();
      mrw(2'b01, nom_word(3'b110, 1'b0, 1'b1));
      tick(D_ON);
      chk_pair("R7 dll-off committed", 3'b110, 3'b110, 1'b0);
      wcmd();
      chk_pair("R7 write under dll-off", 3'b110, 3'b110, 1'b0);
      tick(3);
      chk_pair("R7 write under dll-off later", 3'b110, 3'b110, 1'b0);
      tick(WIN);
      mrw(2'b01, nom_word(3'b110, 1'b0, 1'b0));
      tick(D_ON);
   endtask

   task automatic t_tied_odt();
      mrw(2'b01, nom_word(3'b000, 1'b0, 1'b0));
      tick(D_OFF - 1);
      chk_pair("R10 off latency pending", 3'b110, 3'b110, 1'b1);
      tick(1);
      chk_pair("R8 idle off", 3'b000, 3'b000, 1'b0);
      wcmd();
      chk_pair("R8 write on", 3'b010, 3'b010, 1'b0);
      tick(WIN - 1);
      chk_pair("R8 write last", 3'b010, 3'b010, 1'b0);
      tick(1);
      chk_pair("R8 idle off again", 3'b000, 3'b000, 1'b0);
   endtask

   task automatic t_write_leveling();
      mrw(2'b01, nom_word(3'b010, 1'b1, 1'b0));
      tick(D_ON - 1);
      chk_pair("R10 leveling pending", 3'b000, 3'b000, 1'b1);
      tick(1);
      chk_pair("R9 leveling entered", 3'b000, 3'b010, 1'b0);
      wcmd();
      chk_pair("R9 write ignored in leveling", 3'b000, 3'b010, 1'b0);
      tick(WIN);
      mrw(2'b01, nom_word(3'b000, 1'b0, 1'b0));
      chk_pair("R10 leveling held during exit", 3'b000, 3'b010, 1'b1);
      tick(D_OFF);
      chk_pair("R9 leveling left", 3'b000, 3'b000, 1'b0);
      wcmd();
      chk_pair("R11 normal write after leveling", 3'b010, 3'b010, 1'b0);
      tick(WIN);
   endtask

   initial begin
      t_reset();
      t_nominal_wait();
      t_ignored_banks();
      t_odt_low();
      t_single_write();
      t_back_to_back();
      t_mid_burst_mr();
      t_dll_off();
      t_tied_odt();
      t_write_leveling();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule